// File: doc/BRIEF.md
# Chip Select Enable Decoder

The block holds an 8-bit enable register and decodes a 16-bit memory address into eight active-low chip-select lines. Software writes the register over a simple single-cycle register bus and can read it back. Each bit of the register permits one select. A select goes low only when its bit permits it and the current address falls inside that select's window. The decode is combinational from the address and the registered enables, so a select follows the address within the same cycle.

Two small windows sit inside two large ones. Select 1 covers 0x0100–0x011F and select 2 covers 0x0120–0x013F. Select 3 covers 0x0100–0x01FF and select 6 covers 0x0000–0x7FFF. While a small select is enabled, its range is taken away from selects 3 and 6. Select 3 in turn takes priority over select 6 where the two overlap, so no more than one line is ever low. Select 7 can also be switched on by an external bus-control input. A stack-location flag reports whether the stack lives off chip, which is the case when either of the two large selects is enabled.

Top module: `csel_decoder`

## Requirements
- R1: After reset the enable register reads 0x00, all eight `csN` lines are high and `stackOffChip` is 0.
- R2: A write with `regWe`=1 and `regAddr`=0x7 stores `regWdata` into the enable register at that clock edge. While `regRe`=1 and `regAddr`=0x7, `regRdata` returns the register in the same cycle.
- R3: A write to any `regAddr` other than 0x7 leaves the enable register unchanged. A read of any other address, or any cycle with `regRe`=0, returns 0x00.
- R4: Bit n of the register permits select n. `csN[n]` goes low only when the select is permitted and `memAddr` is inside its window. The default windows are: select 0 0xF000–0xFFFF, select 4 0x8000–0x9FFF, select 5 0xA000–0xBFFF and select 7 0xC000–0xEFFF.
- R5: While bit 1 is set, addresses 0x0100–0x011F assert only `csN[1]`, and neither select 3 nor select 6 responds there.
- R6: While bit 2 is set, addresses 0x0120–0x013F assert only `csN[2]`, and neither select 3 nor select 6 responds there.
- R7: Select 3 covers 0x0100–0x01FF and takes priority over select 6 (0x0000–0x7FFF). When a small select is not enabled, its range falls back to select 3 and then to select 6.
- R8: While `forceSel7`=1, select 7 is permitted whatever register bit 7 holds.
- R9: `stackOffChip` is 1 when register bit 3 or bit 6 is set, and 0 when both are clear. `forceSel7` has no effect on it.
- R10: At most one bit of `csN` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| memAddr | input | 16 | Memory address to decode |
| forceSel7 | input | 1 | External bus-control bit that forces select 7 on |
| csN | output | 8 | Active-low chip selects |
| stackOffChip | output | 1 | 1 when the stack is off chip |

## Verification
Random enable bytes are combined with random addresses, and half of those addresses are drawn from 0x00F0–0x014F. This mix catches every combination of the small selects against select 3 and select 6, which shows whether the carve-outs depend on the enable bits or are fixed. A random `forceSel7` separates the forced path from the register path for select 7. Directed cases walk the window edges, for example 0x011F/0x0120 and 0x013F/0x0140. Writes to other register addresses are confirmed harmless through readback.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int NUM_SEL  = 8;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;

  // Default windows, index = select number
  localparam logic [NUM_SEL-1:0][ADDR_W-1:0] DEF_WIN_LO = {
    16'hC000, 16'h0000, 16'hA000, 16'h8000,
    16'h0100, 16'h0120, 16'h0100, 16'hF000
  };
  localparam logic [NUM_SEL-1:0][ADDR_W-1:0] DEF_WIN_HI = {
    16'hEFFF, 16'h7FFF, 16'hBFFF, 16'h9FFF,
    16'h01FF, 16'h013F, 16'h011F, 16'hFFFF
  };

  typedef struct packed {
    logic wrEnable;
    logic rdEnable;
  } regStrobeT;
endpackage

// File: rtl/csel_ctrl.sv
module csel_ctrl #(
  parameter int REG_ADDR_W   = 4,
  parameter int ENA_REG_ADDR = 7
) (
  input  logic                  regWe,
  input  logic                  regRe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output csel_pkg::regStrobeT   strobes
);
  localparam logic [REG_ADDR_W-1:0] ENA_ADDR = REG_ADDR_W'(ENA_REG_ADDR);

  logic addrHit;

  always_comb begin
    addrHit          = (regAddr == ENA_ADDR);
    strobes.wrEnable = regWe & addrHit;
    strobes.rdEnable = regRe & addrHit;
  end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter logic [NUM_SEL-1:0][ADDR_W-1:0] WIN_LO = DEF_WIN_LO,
  parameter logic [NUM_SEL-1:0][ADDR_W-1:0] WIN_HI = DEF_WIN_HI
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strobes,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic               forceSel7,
  output logic [NUM_SEL-1:0] csN,
  output logic               stackOffChip,
  output logic [NUM_SEL-1:0] enableQ
);
  localparam int SEL_SMALL_A = 1;
  localparam int SEL_SMALL_B = 2;
  localparam int SEL_MID     = 3;
  localparam int SEL_BIG     = 6;
  localparam int SEL_FORCED  = 7;

  logic [NUM_SEL-1:0] effEnable;
  logic [NUM_SEL-1:0] inWindow;
  logic [NUM_SEL-1:0] hit;
  logic [NUM_SEL-1:0] grant;

  // Enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enableQ <= '0;
    else if (strobes.wrEnable) enableQ <= regWdata;
  end

  always_comb begin
    regRdata = strobes.rdEnable ? enableQ : '0;
  end

  always_comb begin
    effEnable             = enableQ;
    effEnable[SEL_FORCED] = enableQ[SEL_FORCED] | forceSel7;
  end

  // Window compare per select
  for (genvar i = 0; i < NUM_SEL; i++) begin : gWin
    always_comb begin
      inWindow[i] = (memAddr >= WIN_LO[i]) && (memAddr <= WIN_HI[i]);
      hit[i]      = inWindow[i] & effEnable[i];
    end
  end

  // Priority among overlapping windows: small A, small B, mid, big
  always_comb begin
    grant              = hit;
    grant[SEL_MID]     = hit[SEL_MID] & ~hit[SEL_SMALL_A] & ~hit[SEL_SMALL_B];
    grant[SEL_BIG]     = hit[SEL_BIG] & ~hit[SEL_SMALL_A] & ~hit[SEL_SMALL_B]
                         & ~hit[SEL_MID];
    csN                = ~grant;
    stackOffChip       = enableQ[SEL_MID] | enableQ[SEL_BIG];
  end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int REG_ADDR_W   = 4,
  parameter int ENA_REG_ADDR = 7,
  parameter logic [NUM_SEL-1:0][ADDR_W-1:0] WIN_LO = DEF_WIN_LO,
  parameter logic [NUM_SEL-1:0][ADDR_W-1:0] WIN_HI = DEF_WIN_HI
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic                  regRe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [ADDR_W-1:0]     memAddr,
  input  logic                  forceSel7,
  output logic [NUM_SEL-1:0]    csN,
  output logic                  stackOffChip
);
  regStrobeT          strobes;
  logic [NUM_SEL-1:0] enableQ;

  csel_ctrl #(
    .REG_ADDR_W  (REG_ADDR_W),
    .ENA_REG_ADDR(ENA_REG_ADDR)
  ) uCtrl (
    .regWe  (regWe),
    .regRe  (regRe),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  csel_datapath #(
    .WIN_LO(WIN_LO),
    .WIN_HI(WIN_HI)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .memAddr     (memAddr),
    .forceSel7   (forceSel7),
    .csN         (csN),
    .stackOffChip(stackOffChip),
    .enableQ     (enableQ)
  );
endmodule

// File: rtl/csel_checker.sv
module csel_checker
  import csel_pkg::*;
#(
  parameter int REG_ADDR_W   = 4,
  parameter int ENA_REG_ADDR = 7
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0]     regWdata,
  input logic [ADDR_W-1:0]     memAddr,
  input logic                  forceSel7,
  input logic [NUM_SEL-1:0]    csN,
  input logic                  stackOffChip,
  input logic [NUM_SEL-1:0]    enableQ
);
  logic wrHit;
  logic inA;
  logic inB;
  logic in7;
  always_comb begin
    wrHit = regWe && (regAddr == REG_ADDR_W'(ENA_REG_ADDR));
    inA   = (memAddr >= DEF_WIN_LO[1]) && (memAddr <= DEF_WIN_HI[1]);
    inB   = (memAddr >= DEF_WIN_LO[2]) && (memAddr <= DEF_WIN_HI[2]);
    in7   = (memAddr >= DEF_WIN_LO[7]) && (memAddr <= DEF_WIN_HI[7]);
  end

  AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R10
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> enableQ == $past(regWdata)); // R2
  AST_OTHER_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(enableQ)); // R3
  AST_SEL0_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ[0] |-> csN[0]); // R4
  AST_SMALL_A_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ[1] && inA) |-> (!csN[1] && csN[3] && csN[6])); // R5
  AST_SMALL_B_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ[2] && inB) |-> (!csN[2] && csN[3] && csN[6])); // R6
  AST_FORCE_SEL7: assert property (@(posedge clk) disable iff (!rstN)
    (forceSel7 && in7) |-> !csN[7]); // R8
  AST_STACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ[3] == 1'b0 && enableQ[6] == 1'b0) |-> !stackOffChip); // R9
endmodule

bind csel_decoder csel_checker #(
  .REG_ADDR_W  (REG_ADDR_W),
  .ENA_REG_ADDR(ENA_REG_ADDR)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regWe       (regWe),
  .regAddr     (regAddr),
  .regWdata    (regWdata),
  .memAddr     (memAddr),
  .forceSel7   (forceSel7),
  .csN         (csN),
  .stackOffChip(stackOffChip),
  .enableQ     (enableQ)
);

// File: tb/sim_csel_decoder.sv
module sim_csel_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic [15:0] memAddr = 16'h0000;
  logic        forceSel7 = 1'b0;
  logic [7:0]  csN;
  logic        stackOffChip;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;

  csel_decoder u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memAddr(memAddr), .forceSel7(forceSel7), .csN(csN),
    .stackOffChip(stackOffChip)
  );

  function automatic bit inRange(input logic [15:0] a, input logic [15:0] lo,
                                 input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [7:0] expCs(input logic [15:0] a, input logic [7:0] en,
                                       input logic frc);
    logic [7:0] g = 8'h00;
    logic [7:0] e = en | {frc, 7'b0};
    if      (e[1] && inRange(a, 16'h0100, 16'h011F)) g[1] = 1'b1;
    else if (e[2] && inRange(a, 16'h0120, 16'h013F)) g[2] = 1'b1;
    else if (e[3] && inRange(a, 16'h0100, 16'h01FF)) g[3] = 1'b1;
    else if (e[6] && inRange(a, 16'h0000, 16'h7FFF)) g[6] = 1'b1;
    if (e[0] && inRange(a, 16'hF000, 16'hFFFF)) g[0] = 1'b1;
    if (e[4] && inRange(a, 16'h8000, 16'h9FFF)) g[4] = 1'b1;
    if (e[5] && inRange(a, 16'hA000, 16'hBFFF)) g[5] = 1'b1;
    if (e[7] && inRange(a, 16'hC000, 16'hEFFF)) g[7] = 1'b1;
    return ~g;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (a == 4'h7) model = d;
  endtask

  task automatic readCheck(input string req);
    regRe = 1'b1; regAddr = 4'h7; #1;
    check(req, "regRdata", {8'h00, regRdata}, {8'h00, model});
    regRe = 1'b0;
  endtask

  task automatic decodeCheck(input string req, input logic [15:0] a, input logic f);
    memAddr = a; forceSel7 = f; #1;
    check(req, "csN", {8'h00, csN}, {8'h00, expCs(a, model, f)});
    check(req, "stackOffChip", {15'h0, stackOffChip},
          {15'h0, (model[3] | model[6])});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R1 reset state
    memAddr = 16'h0110; #1;
    check("R1", "csN", {8'h00, csN}, 16'h00FF);
    check("R1", "stackOffChip", {15'h0, stackOffChip}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck("R1");

    // R2 write and readback
    writeReg(4'h7, 8'hFF);
    readCheck("R2");
    // R3 other addresses ignored
    writeReg(4'h3, 8'h00);
    readCheck("R3");
    regRe = 1'b1; regAddr = 4'h6; #1;
    check("R3", "regRdata other addr", {8'h00, regRdata}, 16'h0000);
    regRe = 1'b0;

    // R5 / R6 / R7 carve-out edges with all enabled
    decodeCheck("R5", 16'h0100, 1'b0);
    decodeCheck("R5", 16'h011F, 1'b0);
    decodeCheck("R6", 16'h0120, 1'b0);
    decodeCheck("R6", 16'h013F, 1'b0);
    decodeCheck("R7", 16'h0140, 1'b0);
    decodeCheck("R7", 16'h00FF, 1'b0);
    decodeCheck("R4", 16'hF000, 1'b0);
    decodeCheck("R4", 16'h9FFF, 1'b0);
    // R7 fall-back when small selects are off
    writeReg(4'h7, 8'b0100_1000);
    decodeCheck("R7", 16'h0105, 1'b0);
    decodeCheck("R7", 16'h0125, 1'b0);
    writeReg(4'h7, 8'b0100_0000);
    decodeCheck("R7", 16'h0105, 1'b0);
    decodeCheck("R9", 16'h8000, 1'b0);
    // R8 force select 7
    writeReg(4'h7, 8'h00);
    decodeCheck("R8", 16'hC000, 1'b1);
    decodeCheck("R8", 16'hEFFF, 1'b0);
    decodeCheck("R9", 16'hC000, 1'b1);
    // R4 disabled selects stay high
    decodeCheck("R4", 16'hF123, 1'b0);

    // Random mix: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      if ($urandom_range(0, 3) == 0)
        writeReg(4'($urandom_range(0, 15)), 8'($urandom));
      if ($urandom_range(0, 1) == 0) a = 16'($urandom_range(16'h00F0, 16'h014F));
      else                           a = 16'($urandom);
      decodeCheck("R10", a, 1'($urandom));
      checks++;
      if ($countones(~csN) > 1) begin
        fails++;
        $display("FAIL R10 csN actual %h expected at most one low", csN);
      end
      if (i % 50 == 0) readCheck("R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule